// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Pause

This block is the pin-facing serial slave interface of a serial memory device. A fast system clock oversamples the select, serial clock, serial data in and pause pins. The block turns the incoming bit stream into bytes for the command logic. It marks the byte that opens each transaction as the command byte. It shifts bytes supplied by the core out on the serial data output, and it drives the enable of the tri-state output driver.

A pause pin lets the host stop serial traffic in the middle of a transaction without ending it. While paused, serial clock edges and input data have no effect, the output driver is off, and the bit position is kept. A busy flag from the internal self-timed write engine passes straight through to the block's outputs. The same flag delays the standby indication after deselect until the engine has finished.

Top module: `sflash_serial_frontend`

## Requirements
- R1: A transaction opens on a high-to-low change of `sel_n` and closes on a low-to-high change. Both changes clear the bit position and the byte state, so a partial byte left from an earlier transaction never merges with a new one.
- R2: With `sel_n` low, `sdi` is captured on each rising edge of `sclk`, most significant bit first. After the eighth capture, `rx_valid` pulses high for exactly one system clock with the assembled byte on `rx_data`.
- R3: `rx_first` is 1 alongside the first completed byte of a transaction and 0 alongside every later byte of it.
- R4: `sdo` changes only on falling edges of `sclk`. At the falling edge that follows the eighth rising edge of each byte, the value on `tx_data` is loaded and its bit 7 is driven. The following falling edges drive the lower bits in order. `tx_req` pulses for one system clock at the falling edge that follows the seventh rising edge of each byte. `sdo` is 0 from the opening of a transaction until the first load.
- R5: While `sel_n` is high, `sclk` and `sdi` have no effect: no byte is reported. `sdo_oe` is 0.
- R6: While paused, `sclk` edges and `sdi` are ignored and `sdo_oe` is 0. The bit position is kept, so a byte interrupted by a pause completes correctly after it.
- R7: A pause begins only when `pause_n` is low, `sel_n` is low and `sclk` is low. A request made while `sclk` is high waits until `sclk` goes low.
- R8: A pause ends only when `pause_n` is high and `sclk` is low. A release made while `sclk` is high waits until `sclk` goes low.
- R9: `busy_out` follows `core_busy` at all times, whether or not the interface is paused.
- R10: `standby` is 1 only when `sel_n` is high and `core_busy` is low. It follows `core_busy` one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Device select pin, active low |
| sclk | input | 1 | Serial clock pin |
| sdi | input | 1 | Serial data input pin |
| pause_n | input | 1 | Pause pin, active low |
| core_busy | input | 1 | Self-timed write engine busy flag |
| tx_data | input | DATA_W | Next byte to shift out, held valid from `tx_req` until the next falling `sclk` edge |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output driver enable, 1 = drive `sdo` |
| rx_data | output | DATA_W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a completed byte |
| rx_first | output | 1 | Completed byte is the first of its transaction |
| tx_req | output | 1 | One-cycle request for the next output byte |
| busy_out | output | 1 | Busy flag passed through |
| standby | output | 1 | Device may enter standby |

## Verification
The byte path is tested with several kinds of transactions. A clean three-byte transfer checks bit order, the first-byte flag, the one-byte output offset and the request count. A transaction cut after three bits, followed by a fresh one, shows whether the counters really clear at select. Clock and data toggles sent while deselected show whether the select gating works.

Pause tests send clock pulses and inverted data while paused. They separate frozen bit handling from edges that still leak through. A pause asserted and released while `sclk` is high shows whether entry and exit wait for the clock to go low. The standby tests walk `sel_n` and `core_busy` through their combinations.

// File: rtl/sfe_pkg.sv
// Shared constants and types for the serial front-end.
// Assumes the four pins are packed into one vector in the order given below.
package sfe_pkg;
    localparam int PIN_N     = 4;
    localparam int PIN_SEL   = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_SDI   = 2;
    localparam int PIN_PAUSE = 3;
    // idle levels: select high, clock low, data low, pause released
    localparam logic [PIN_N-1:0] PIN_IDLE = 4'b1001;

    // per-cycle transaction and serial clock events, already gated
    typedef struct packed {
        logic open;   // select went active
        logic close;  // select went inactive
        logic rise;   // accepted rising serial clock edge
        logic fall;   // accepted falling serial clock edge
    } sfe_evt_t;
endpackage

// File: rtl/sfe_pin_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes pins change slowly against clk; each bit is synchronized on its own.
module sfe_pin_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_lvl
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        if (STAGES == 1) begin : g_single
            // single stage register
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= RST_VAL;
                else        stage_q[0] <= pin_in;
            end
        end else begin : g_chain
            // shift the pins through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= {STAGES{RST_VAL}};
                else        stage_q <= {stage_q[STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign pin_lvl = stage_q[STAGES-1];
endmodule

// File: rtl/sfe_pause_ctrl.sv
// Pause state machine: enters and leaves the paused state only while the
// synchronized serial clock is low and the device is selected.
// Assumes inputs are already synchronized to clk.
module sfe_pause_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_act,
    input  logic sclk_lvl,
    input  logic pause_n_lvl,
    output logic paused
);
    // track pause state, gated on clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
        end else if (!sel_act) begin
            paused <= 1'b0;
        end else if (!paused && !pause_n_lvl && !sclk_lvl) begin
            paused <= 1'b1;
        end else if (paused && pause_n_lvl && !sclk_lvl) begin
            paused <= 1'b0;
        end
    end

    // R7
    // pause_entry_chk
    pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(!sclk_lvl && sel_act && !pause_n_lvl));

    // R8
    // pause_exit_chk
    pause_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(paused) && $past(sel_act) && sel_act) |-> $past(pause_n_lvl && !sclk_lvl));
endmodule

// File: rtl/sfe_rx_shift.sv
// Receive shifter: captures serial data on accepted rising edges, MSB first,
// and reports each completed byte with a one-cycle strobe.
// Assumes evt.rise is already gated by select and pause.
module sfe_rx_shift
    import sfe_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sfe_evt_t          evt,
    input  logic              paused,
    input  logic              sdi_lvl,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic              first_pend;

    // shift in bits, count them and publish completed bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_first   <= 1'b0;
            first_pend <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (evt.open || evt.close) begin
                bit_cnt    <= '0;
                shreg      <= '0;
                first_pend <= evt.open;
            end else if (evt.rise) begin
                shreg <= {shreg[DATA_W-2:0], sdi_lvl};
                if (bit_cnt == LAST) begin
                    bit_cnt    <= '0;
                    rx_valid   <= 1'b1;
                    rx_data    <= {shreg[DATA_W-2:0], sdi_lvl};
                    rx_first   <= first_pend;
                    first_pend <= 1'b0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2
    // rx_pulse_chk
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    // pause_hold_chk
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !evt.open && !evt.close) |=> $stable(bit_cnt));
endmodule

// File: rtl/sfe_tx_shift.sv
// Transmit shifter: launches output bits on accepted falling edges, loading a
// new byte at the first falling edge after a byte boundary and requesting the
// next byte one falling edge earlier.
// Assumes the core holds tx_data valid from tx_req to the next falling edge.
module sfe_tx_shift
    import sfe_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sfe_evt_t          evt,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo,
    output logic              tx_req
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] out_sr;

    // launch bits on falling edges and raise the next-byte request
    always_ff @(posedge clk) begin
        if (!rst_n || evt.open) begin
            out_sr <= '0;
            sdo    <= 1'b0;
            tx_req <= 1'b0;
        end else begin
            tx_req <= 1'b0;
            if (evt.fall) begin
                if (bit_cnt == '0) begin
                    sdo    <= tx_data[DATA_W-1];
                    out_sr <= {tx_data[DATA_W-2:0], 1'b0};
                end else begin
                    sdo    <= out_sr[DATA_W-1];
                    out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                end
                if (bit_cnt == LAST) tx_req <= 1'b1;
            end
        end
    end

    // R4
    // tx_req_pulse_chk
    tx_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R4
    // sdo_on_fall_chk
    sdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(evt.fall) && !$past(evt.open)) |-> $stable(sdo));
endmodule

// File: rtl/sflash_serial_frontend.sv
// Serial slave front-end of a memory device: synchronizes the pins, detects
// select and serial clock edges, gates them with the pause state, and
// connects receive and transmit shifters. Also drives the output enable,
// passes the busy flag through and reports standby readiness.
// Assumes clk runs at least four times faster than sclk.
module sflash_serial_frontend
    import sfe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              pause_n,
    input  logic              core_busy,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              tx_req,
    output logic              busy_out,
    output logic              standby
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [PIN_N-1:0] pin_raw;
    logic [PIN_N-1:0] pin_lvl;
    logic             sel_prev;
    logic             sclk_prev;
    logic             sel_act;
    logic             paused;
    logic             live;
    sfe_evt_t         evt;
    logic [CNT_W-1:0] bit_cnt;

    assign pin_raw[PIN_SEL]   = sel_n;
    assign pin_raw[PIN_SCLK]  = sclk;
    assign pin_raw[PIN_SDI]   = sdi;
    assign pin_raw[PIN_PAUSE] = pause_n;

    sfe_pin_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_raw),
        .pin_lvl (pin_lvl)
    );

    // remember previous select and clock levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_prev  <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            sel_prev  <= pin_lvl[PIN_SEL];
            sclk_prev <= pin_lvl[PIN_SCLK];
        end
    end

    // derive gated events from synchronized levels
    always_comb begin
        sel_act   = !pin_lvl[PIN_SEL];
        live      = sel_act && !paused;
        evt.open  = !pin_lvl[PIN_SEL] && sel_prev;
        evt.close = pin_lvl[PIN_SEL] && !sel_prev;
        evt.rise  = live && pin_lvl[PIN_SCLK] && !sclk_prev;
        evt.fall  = live && !pin_lvl[PIN_SCLK] && sclk_prev;
    end

    sfe_pause_ctrl u_pause (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_act     (sel_act),
        .sclk_lvl    (pin_lvl[PIN_SCLK]),
        .pause_n_lvl (pin_lvl[PIN_PAUSE]),
        .paused      (paused)
    );

    sfe_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .paused   (paused),
        .sdi_lvl  (pin_lvl[PIN_SDI]),
        .bit_cnt  (bit_cnt),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_first (rx_first)
    );

    sfe_tx_shift #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .bit_cnt (bit_cnt),
        .tx_data (tx_data),
        .sdo     (sdo),
        .tx_req  (tx_req)
    );

    // output enable and standby readiness
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdo_oe  <= 1'b0;
            standby <= 1'b0;
        end else begin
            sdo_oe  <= live;
            standby <= !sel_act && !core_busy;
        end
    end

    assign busy_out = core_busy;

    // R5
    // desel_quiet_chk
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (!sdo_oe && !rx_valid));

    // R10
    // standby_idle_chk
    standby_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !sdo_oe);
endmodule

// File: tb/tb_sflash_serial_frontend.sv
module tb_sflash_serial_frontend;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       pause_n = 1'b1;
    logic       core_busy = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       sdo, sdo_oe, rx_valid, rx_first, tx_req, busy_out, standby;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sflash_serial_frontend dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .pause_n(pause_n), .core_busy(core_busy), .tx_data(tx_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_first(rx_first), .tx_req(tx_req), .busy_out(busy_out), .standby(standby)
    );

    // received byte log and core-side byte supplier
    logic [7:0] rx_buf [64];
    logic       first_buf [64];
    int         rx_n = 0;
    int         req_n = 0;

    function automatic logic [7:0] pat(int k);
        return 8'h5A + 8'(k * 29);
    endfunction

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_buf[rx_n % 64]    <= rx_data;
            first_buf[rx_n % 64] <= rx_first;
            rx_n <= rx_n + 1;
        end
        if (tx_req) begin
            tx_data <= pat(req_n);
            req_n   <= req_n + 1;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bit: set data, sample sdo, rising edge, falling edge
    task automatic send_bit(input logic b, output logic got);
        sdi = b;
        tick(4);
        got = sdo;
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) send_bit(b[i], got[i]);
    endtask

    task automatic end_xfer();
        tick(4);
        sel_n = 1'b1;
        tick(6);
    endtask

    task automatic test_reset();
        tick(4);
        check(sdo_oe == 1'b0, "R5 reset oe", sdo_oe, 0);
        check(rx_valid == 1'b0 && tx_req == 1'b0, "R2 reset strobes", {rx_valid, tx_req}, 0);
        check(standby == 1'b1, "R10 reset standby", standby, 1);
        check(busy_out == 1'b0, "R9 reset busy", busy_out, 0);
    endtask

    task automatic test_deselected();
        int base = rx_n;
        logic [7:0] g;
        send_byte(8'hC7, g);
        send_byte(8'h3B, g);
        check(rx_n == base, "R5 no byte while deselected", rx_n - base, 0);
        check(sdo_oe == 1'b0, "R5 oe low while deselected", sdo_oe, 0);
    endtask

    task automatic test_basic();
        int base = rx_n;
        int rbase = req_n;
        logic [7:0] g0, g1, g2;
        sel_n = 1'b0;
        tick(6);
        check(sdo_oe == 1'b1, "R5 oe high when selected", sdo_oe, 1);
        check(standby == 1'b0, "R10 no standby when selected", standby, 0);
        send_byte(8'h9F, g0);
        send_byte(8'h12, g1);
        send_byte(8'hA5, g2);
        tick(4);
        check(rx_n - base == 3, "R2 byte count", rx_n - base, 3);
        check(rx_buf[base % 64] == 8'h9F, "R2 byte0", rx_buf[base % 64], 8'h9F);
        check(rx_buf[(base + 1) % 64] == 8'h12, "R2 byte1", rx_buf[(base + 1) % 64], 8'h12);
        check(rx_buf[(base + 2) % 64] == 8'hA5, "R2 byte2", rx_buf[(base + 2) % 64], 8'hA5);
        check(first_buf[base % 64] == 1'b1, "R3 first flag set", first_buf[base % 64], 1);
        check(first_buf[(base + 1) % 64] == 1'b0 && first_buf[(base + 2) % 64] == 1'b0,
              "R3 first flag clear", {first_buf[(base + 1) % 64], first_buf[(base + 2) % 64]}, 0);
        check(g0 == 8'h00, "R4 sdo before first load", g0, 0);
        check(g1 == pat(rbase), "R4 out byte0", g1, pat(rbase));
        check(g2 == pat(rbase + 1), "R4 out byte1", g2, pat(rbase + 1));
        check(req_n - rbase == 3, "R4 request count", req_n - rbase, 3);
        end_xfer();
    endtask

    task automatic test_abort();
        int base = rx_n;
        logic g;
        logic [7:0] gb;
        sel_n = 1'b0;
        tick(6);
        send_bit(1'b1, g);
        send_bit(1'b1, g);
        send_bit(1'b0, g);
        end_xfer();
        sel_n = 1'b0;
        tick(6);
        send_byte(8'h5E, gb);
        tick(4);
        check(rx_n - base == 1, "R1 one byte after restart", rx_n - base, 1);
        check(rx_buf[base % 64] == 8'h5E, "R1 partial bits dropped", rx_buf[base % 64], 8'h5E);
        check(first_buf[base % 64] == 1'b1, "R1 R3 restart is command", first_buf[base % 64], 1);
        end_xfer();
    endtask

    task automatic test_pause();
        int base = rx_n;
        logic g;
        logic [7:0] b = 8'hB4;
        sel_n = 1'b0;
        tick(6);
        for (int i = 7; i >= 4; i--) send_bit(b[i], g);
        tick(4);
        pause_n = 1'b0;
        tick(6);
        check(sdo_oe == 1'b0, "R6 oe low while paused", sdo_oe, 0);
        core_busy = 1'b1;
        tick(2);
        check(busy_out == 1'b1, "R9 busy passes while paused", busy_out, 1);
        for (int k = 0; k < 3; k++) begin
            sdi = ~sdi;
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
        end
        pause_n = 1'b1;
        tick(6);
        check(sdo_oe == 1'b1, "R8 resume when clock low", sdo_oe, 1);
        core_busy = 1'b0;
        tick(2);
        check(busy_out == 1'b0, "R9 busy clears", busy_out, 0);
        for (int i = 3; i >= 0; i--) send_bit(b[i], g);
        tick(4);
        check(rx_n - base == 1, "R6 one byte across pause", rx_n - base, 1);
        check(rx_buf[base % 64] == b, "R6 byte intact across pause", rx_buf[base % 64], b);
        end_xfer();
    endtask

    task automatic test_pause_deferred();
        int base = rx_n;
        logic g;
        logic [7:0] b = 8'h69;
        sel_n = 1'b0;
        tick(6);
        for (int i = 7; i >= 5; i--) send_bit(b[i], g);
        sdi = b[4];
        tick(4);
        sclk = 1'b1;
        tick(2);
        pause_n = 1'b0;
        tick(6);
        check(sdo_oe == 1'b1, "R7 no pause while clock high", sdo_oe, 1);
        sclk = 1'b0;
        tick(6);
        check(sdo_oe == 1'b0, "R7 pause after clock low", sdo_oe, 0);
        sdi = ~b[3];
        sclk = 1'b1;
        tick(4);
        pause_n = 1'b1;
        tick(6);
        check(sdo_oe == 1'b0, "R8 stay paused while clock high", sdo_oe, 0);
        sclk = 1'b0;
        tick(6);
        check(sdo_oe == 1'b1, "R8 release after clock low", sdo_oe, 1);
        for (int i = 3; i >= 0; i--) send_bit(b[i], g);
        tick(4);
        check(rx_n - base == 1 && rx_buf[base % 64] == b, "R7 byte intact",
              rx_buf[base % 64], b);
        end_xfer();
    endtask

    task automatic test_standby();
        core_busy = 1'b1;
        tick(3);
        check(standby == 1'b0, "R10 busy blocks standby", standby, 0);
        check(busy_out == 1'b1, "R9 busy passes", busy_out, 1);
        core_busy = 1'b0;
        tick(2);
        check(standby == 1'b1, "R10 standby after busy clears", standby, 1);
        sel_n = 1'b0;
        tick(6);
        check(standby == 1'b0, "R10 no standby selected idle", standby, 0);
        sel_n = 1'b1;
        tick(6);
        check(standby == 1'b1, "R10 standby after deselect", standby, 1);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        test_reset();
        test_deselected();
        test_basic();
        test_abort();
        test_pause();
        test_pause_deferred();
        test_standby();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule